// File: doc/BRIEF.md
# Depth-Cascade Match Priority Arbiter

This block sits in every lookup device of a depth cascade of up to eight devices that share one result bus. Each cycle in which the local ternary array reports a lookup outcome, the block registers that outcome. It raises a match line that every lower-priority device samples. One cycle later, all devices use the match lines from their higher-priority peers to decide together which of them may place its result on the shared index bus.

A device with a local hit and no higher-priority hit drives the index. The index is made of its strapped device address, the lookup type and the matched location. When no device hits, the device strapped as last in the chain drives a no-match result that is still marked valid. The device strapped as the SRAM owner drives the SRAM chip-enable when any device up to and including itself has hit. It also keeps the index bus driven between operations so that the bus never floats. A multi-match flag combines several hits inside the local segments with a hit that overlaps a higher-priority device.

Top module: `casc_match_arbiter`

## Requirements
- R1: `match_out` is 1 in the cycle after the clock edge that samples `lk_valid`=1 with at least one bit of `seg_hit` set. In any other case it is 0.
- R2: Bit k of `match_in` carries the match line of the device with address k. Only bits whose index is strictly below `dev_addr` count as a higher-priority hit. All other bits have no effect on any output.
- R3: A local hit with no higher-priority hit gives `idx_drive`=1, `idx_valid`=1 and `idx_hit`=1 on the second edge after the lookup. `idx` is then {`dev_addr`[2:0], `lk_type`[1:0], `lk_loc`[14:0]}, with the device address in the most significant bits.
- R4: If a higher-priority hit is present for a lookup, the device releases the bus for that result: `idx_drive`=0, `idx_valid`=0 and `idx_hit`=0.
- R5: A lookup with no local hit and no higher-priority hit, on a device with `last_dev`=1, gives `idx_drive`=1, `idx_valid`=1 and `idx_hit`=0. `idx` is then {`dev_addr`, `lk_type`, 15'b0}.
- R6: A lookup result for which the device is neither the winner nor the no-match driver gives `idx_drive`=0. This holds even when `last_sram`=1.
- R7: `multi_out` is 1 for a local hit when any bit of `seg_multi` is set or when two or more bits of `seg_hit` are set. A single segment hit with no `seg_multi` bit and no higher-priority hit gives 0.
- R8: `multi_out` is 1 when a local hit coincides with a higher-priority hit, even though the device does not drive the bus.
- R9: In a cycle with no lookup result, `idx_drive` equals `last_sram` and `idx_valid`, `idx_hit`, `multi_out` and `sram_ce` are 0. `idx` keeps its previous value.
- R10: `sram_ce` is 1 for a lookup result only on a device with `last_sram`=1 when there is a local hit or a higher-priority hit. Otherwise it is 0.
- R11: While `rst_n` is 0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Local lookup outcome present this cycle |
| seg_hit | input | 4 | Per-segment hit from the local array |
| seg_multi | input | 4 | Per-segment several-hits flag |
| lk_loc | input | 15 | Highest-priority matched location in the local array |
| lk_type | input | 2 | Lookup type code carried into the index |
| match_in | input | 8 | Match lines of the other devices, bit k from address k |
| dev_addr | input | 3 | Strapped device address; lower value means higher priority |
| last_dev | input | 1 | Strap: device drives the no-match result |
| last_sram | input | 1 | Strap: device owns SRAM control and idle bus hold |
| match_out | output | 1 | Registered local hit for lower-priority devices |
| idx_drive | output | 1 | Enable for this device's index bus drivers |
| idx | output | 20 | Composed index {device address, type, location} |
| idx_valid | output | 1 | Index carries a completed lookup result |
| idx_hit | output | 1 | Index carries a hit (0 for the no-match result) |
| multi_out | output | 1 | Multi-match contribution of this device |
| sram_ce | output | 1 | SRAM chip enable for a hit result |

## Verification
The case most likely to break is the SRAM-owner device with its own lookup result in the same cycle. Its idle bus hold has to give way to the cascade decision, and its SRAM enable has to follow upstream hits it does not own. The directed case straps `last_sram`=1 with a higher-priority match line raised. It then expects `idx_drive`=0 and `sram_ce`=1 on the result cycle, and the hold to return one cycle later with the index unchanged. A second overlap puts the local multi-segment condition and the cross-device condition on the same result, so that `multi_out` rises once while the bus is released.

// File: rtl/casc_pkg.sv
package casc_pkg;
    parameter int CASC_MAX_DEV = 8;
    parameter int CASC_NUM_SEG = 4;
    parameter int CASC_LOC_W   = 15;
    parameter int CASC_TYPE_W  = 2;
    localparam int CASC_DEV_AW = $clog2(CASC_MAX_DEV);
    localparam int CASC_IDX_W  = CASC_DEV_AW + CASC_TYPE_W + CASC_LOC_W;

    // first stage: local lookup outcome
    typedef struct packed {
        logic                   valid;
        logic                   hit;
        logic                   multi;
        logic [CASC_TYPE_W-1:0] ltype;
        logic [CASC_LOC_W-1:0]  loc;
    } casc_local_t;

    // second stage: bus decision
    typedef struct packed {
        logic                  drive;
        logic                  valid;
        logic                  hit;
        logic                  multi;
        logic                  sram_ce;
        logic [CASC_IDX_W-1:0] idx;
    } casc_drive_t;
endpackage

// File: rtl/casc_local_stage.sv
module casc_local_stage
    import casc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lk_valid,
    input  logic [CASC_NUM_SEG-1:0] seg_hit,
    input  logic [CASC_NUM_SEG-1:0] seg_multi,
    input  logic [CASC_LOC_W-1:0]   lk_loc,
    input  logic [CASC_TYPE_W-1:0]  lk_type,
    output casc_local_t             s1_q,
    output logic                    match_out
);
    localparam int CNT_W = $clog2(CASC_NUM_SEG + 1);

    casc_local_t    s1_d;
    logic [CNT_W-1:0] hit_cnt;

    always_comb begin
        hit_cnt = '0;
        for (int s = 0; s < CASC_NUM_SEG; s++) begin
            hit_cnt = hit_cnt + CNT_W'(seg_hit[s]);
        end
    end

    always_comb begin
        s1_d       = s1_q;
        s1_d.valid = lk_valid;
        s1_d.hit   = lk_valid && (seg_hit != '0);
        s1_d.multi = lk_valid && (seg_hit != '0) &&
                     ((seg_multi != '0) || (hit_cnt > CNT_W'(1)));
        if (lk_valid) begin
            s1_d.ltype = lk_type;
            s1_d.loc   = lk_loc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
        end else begin
            s1_q <= s1_d;
        end
    end

    assign match_out = s1_q.hit;

    // R1
    match_follows_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && (seg_hit != '0)) |=> match_out);

    // R1
    no_match_without_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !match_out);
endmodule

// File: rtl/casc_upstream_mask.sv
module casc_upstream_mask
    import casc_pkg::*;
(
    input  logic [CASC_MAX_DEV-1:0] match_in,
    input  logic [CASC_DEV_AW-1:0]  dev_addr,
    output logic                    up_any
);
    logic [CASC_MAX_DEV-1:0] eligible;

    for (genvar k = 0; k < CASC_MAX_DEV; k++) begin : g_line
        // only devices with a smaller address outrank this one
        assign eligible[k] = match_in[k] && (CASC_DEV_AW'(k) < dev_addr);
    end

    assign up_any = |eligible;

    // R2
    top_device_ignores_lines_chk: assert final ((dev_addr != '0) || !up_any);
endmodule

// File: rtl/casc_drive_stage.sv
module casc_drive_stage
    import casc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  casc_local_t            s1_q,
    input  logic                   up_any,
    input  logic [CASC_DEV_AW-1:0] dev_addr,
    input  logic                   last_dev,
    input  logic                   last_sram,
    output casc_drive_t            s2_q
);
    casc_drive_t s2_d;

    always_comb begin
        s2_d         = s2_q;
        s2_d.valid   = 1'b0;
        s2_d.hit     = 1'b0;
        s2_d.multi   = 1'b0;
        s2_d.sram_ce = 1'b0;
        if (s1_q.valid) begin
            s2_d.drive   = 1'b0;
            s2_d.multi   = s1_q.hit && (s1_q.multi || up_any);
            s2_d.sram_ce = last_sram && (s1_q.hit || up_any);
            if (!up_any && s1_q.hit) begin
                s2_d.drive = 1'b1;
                s2_d.valid = 1'b1;
                s2_d.hit   = 1'b1;
                s2_d.idx   = {dev_addr, s1_q.ltype, s1_q.loc};
            end else if (!up_any && last_dev) begin
                s2_d.drive = 1'b1;
                s2_d.valid = 1'b1;
                s2_d.idx   = {dev_addr, s1_q.ltype, {CASC_LOC_W{1'b0}}};
            end
        end else begin
            // idle: SRAM owner keeps the bus from floating
            s2_d.drive = last_sram;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_q <= '0;
        end else begin
            s2_q <= s2_d;
        end
    end

    // R3
    winner_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_q.valid && s1_q.hit && !up_any) |=> (s2_q.drive && s2_q.hit && s2_q.valid));

    // R4
    yield_to_upstream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_q.valid && up_any) |=> (!s2_q.drive && !s2_q.valid));

    // R8
    cross_multi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_q.valid && s1_q.hit && up_any) |=> s2_q.multi);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s1_q.valid && last_sram) |=> (s2_q.drive && !s2_q.valid && $stable(s2_q.idx)));

    // R10
    sram_owner_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s2_q.sram_ce |-> $past(last_sram));
endmodule

// File: rtl/casc_match_arbiter.sv
module casc_match_arbiter
    import casc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lk_valid,
    input  logic [CASC_NUM_SEG-1:0] seg_hit,
    input  logic [CASC_NUM_SEG-1:0] seg_multi,
    input  logic [CASC_LOC_W-1:0]   lk_loc,
    input  logic [CASC_TYPE_W-1:0]  lk_type,
    input  logic [CASC_MAX_DEV-1:0] match_in,
    input  logic [CASC_DEV_AW-1:0]  dev_addr,
    input  logic                    last_dev,
    input  logic                    last_sram,
    output logic                    match_out,
    output logic                    idx_drive,
    output logic [CASC_IDX_W-1:0]   idx,
    output logic                    idx_valid,
    output logic                    idx_hit,
    output logic                    multi_out,
    output logic                    sram_ce
);
    casc_local_t s1_q;
    casc_drive_t s2_q;
    logic        up_any;

    casc_local_stage u_local (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (lk_valid),
        .seg_hit   (seg_hit),
        .seg_multi (seg_multi),
        .lk_loc    (lk_loc),
        .lk_type   (lk_type),
        .s1_q      (s1_q),
        .match_out (match_out)
    );

    casc_upstream_mask u_mask (
        .match_in (match_in),
        .dev_addr (dev_addr),
        .up_any   (up_any)
    );

    casc_drive_stage u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_q      (s1_q),
        .up_any    (up_any),
        .dev_addr  (dev_addr),
        .last_dev  (last_dev),
        .last_sram (last_sram),
        .s2_q      (s2_q)
    );

    assign idx_drive = s2_q.drive;
    assign idx       = s2_q.idx;
    assign idx_valid = s2_q.valid;
    assign idx_hit   = s2_q.hit;
    assign multi_out = s2_q.multi;
    assign sram_ce   = s2_q.sram_ce;

    // R7
    multi_implies_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        multi_out |-> $past(match_out));
endmodule

// File: tb/casc_match_arbiter_tb.sv
module casc_match_arbiter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid;
    logic [3:0]  seg_hit, seg_multi;
    logic [14:0] lk_loc;
    logic [1:0]  lk_type;
    logic [7:0]  match_in;
    logic [2:0]  dev_addr;
    logic        last_dev, last_sram;
    logic        match_out, idx_drive, idx_valid, idx_hit, multi_out, sram_ce;
    logic [19:0] idx;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    casc_match_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .seg_hit(seg_hit),
        .seg_multi(seg_multi), .lk_loc(lk_loc), .lk_type(lk_type),
        .match_in(match_in), .dev_addr(dev_addr), .last_dev(last_dev),
        .last_sram(last_sram), .match_out(match_out), .idx_drive(idx_drive),
        .idx(idx), .idx_valid(idx_valid), .idx_hit(idx_hit),
        .multi_out(multi_out), .sram_ce(sram_ce)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    // drive one lookup; returns at the negedge where stage-two outputs are visible
    task automatic run_op(input logic [3:0] sh, input logic [3:0] sm,
                          input logic [14:0] loc, input logic [1:0] ty,
                          input logic [7:0] up, input logic exp_match);
        @(negedge clk);
        lk_valid = 1'b1; seg_hit = sh; seg_multi = sm; lk_loc = loc; lk_type = ty;
        @(negedge clk);
        chk("R1 match_out", match_out, exp_match);
        lk_valid = 1'b0; seg_hit = '0; seg_multi = '0; match_in = up;
        @(negedge clk);
        match_in = '0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; lk_valid = 0; seg_hit = 0; seg_multi = 0; lk_loc = 0;
        lk_type = 0; match_in = 0; dev_addr = 3'd2; last_dev = 1; last_sram = 1;
        repeat (3) @(negedge clk);
        chk("R11 drive", idx_drive, 0);
        chk("R11 idx", idx, 0);
        chk("R11 flags", {match_out, idx_valid, idx_hit, multi_out, sram_ce}, 0);
        rst_n = 1'b1;
        last_dev = 0; last_sram = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_win;
        run_op(4'b0100, 4'b0000, 15'h1234, 2'd3, 8'h00, 1'b1);
        chk("R3 drive", idx_drive, 1);
        chk("R3 valid/hit", {idx_valid, idx_hit}, 2'b11);
        chk("R3 idx", idx, {3'd2, 2'd3, 15'h1234});
        chk("R7 single hit no multi", multi_out, 0);
        chk("R10 non-owner ce", sram_ce, 0);
    endtask

    task automatic t_yield;
        run_op(4'b0001, 4'b0000, 15'h0042, 2'd1, 8'h01, 1'b1);
        chk("R4 drive", idx_drive, 0);
        chk("R4 valid/hit", {idx_valid, idx_hit}, 2'b00);
        chk("R8 cross multi", multi_out, 1);
    endtask

    task automatic t_ignore_lower;
        run_op(4'b0010, 4'b0000, 15'h7001, 2'd2, 8'b1110_0100, 1'b1);
        chk("R2 ignored lines drive", idx_drive, 1);
        chk("R2 ignored lines idx", idx, {3'd2, 2'd2, 15'h7001});
        chk("R2 ignored lines multi", multi_out, 0);
    endtask

    task automatic t_nomatch_last;
        last_dev = 1;
        run_op(4'b0000, 4'b0000, 15'h5555, 2'd1, 8'h00, 1'b0);
        chk("R5 drive", idx_drive, 1);
        chk("R5 valid/hit", {idx_valid, idx_hit}, 2'b10);
        chk("R5 idx", idx, {3'd2, 2'd1, 15'h0});
        last_dev = 0;
    endtask

    task automatic t_nomatch_mid;
        run_op(4'b0000, 4'b0000, 15'h0001, 2'd0, 8'h00, 1'b0);
        chk("R6 drive", idx_drive, 0);
        chk("R6 valid", idx_valid, 0);
    endtask

    task automatic t_local_multi;
        run_op(4'b1010, 4'b0000, 15'h0010, 2'd0, 8'h00, 1'b1);
        chk("R7 two segments", multi_out, 1);
        run_op(4'b0001, 4'b0001, 15'h0011, 2'd0, 8'h00, 1'b1);
        chk("R7 segment multi", multi_out, 1);
        chk("R7 still drives", idx_drive, 1);
    endtask

    task automatic t_owner_overlap;
        last_sram = 1;
        run_op(4'b0001, 4'b0000, 15'h0abc, 2'd2, 8'h00, 1'b1);
        chk("R10 owner hit ce", sram_ce, 1);
        @(negedge clk);
        chk("R9 idle hold drive", idx_drive, 1);
        chk("R9 idle idx kept", idx, {3'd2, 2'd2, 15'h0abc});
        chk("R9 idle flags", {idx_valid, idx_hit, multi_out, sram_ce}, 0);
        // owner loses to upstream while holding the bus
        run_op(4'b0000, 4'b0000, 15'h0333, 2'd0, 8'h02, 1'b0);
        chk("R6 owner releases", idx_drive, 0);
        chk("R10 upstream ce", sram_ce, 1);
        @(negedge clk);
        chk("R9 hold returns", idx_drive, 1);
        chk("R9 idx unchanged", idx, {3'd2, 2'd2, 15'h0abc});
        run_op(4'b0000, 4'b0000, 15'h0333, 2'd0, 8'h00, 1'b0);
        chk("R10 no hit ce", sram_ce, 0);
        last_sram = 0;
        @(negedge clk);
        @(negedge clk);
        chk("R9 non-owner idle", idx_drive, 0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_win();
        t_yield();
        t_ignore_lower();
        t_nomatch_last();
        t_nomatch_mid();
        t_local_multi();
        t_owner_overlap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule